// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between a CPU's 16-bit address bus and the ROM and RAM chips of a plug-in cartridge. The CPU cannot write to ROM, so writes into the ROM address range are used as commands instead. They load four small control registers: a RAM enable flag, a 5-bit low bank number, a 2-bit high bank number and a banking mode bit. Based on those registers, the block translates every CPU address that falls in the two ROM windows or the external RAM window into a physical ROM or RAM address. It also drives the chip selects for both memories.

The upper ROM window (0x4000–0x7FFF) always shows the bank formed from both bank registers together. In mode 0, the lower ROM window (0x0000–0x3FFF) and the RAM window (0xA000–0xBFFF) are fixed to bank 0. Setting the mode bit lets the 2-bit high register bank the lower ROM window and the RAM window as well. Every computed bank number is masked to the number of banks that are actually fitted, and those counts are parameters. The translation is purely combinational; only the control registers hold state.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After a synchronous reset, the low bank register reads as 1, and the high bank register, mode bit and RAM enable read as 0. So a read of 0x4000 maps to physical ROM 0x04000, and a RAM-window read gets no RAM select.
- R2: A write anywhere in 0x0000–0x1FFF enables RAM when data bits 3:0 equal 0xA, whatever bits 7:4 hold. Any other low nibble disables RAM. The new value takes effect from the next clock cycle.
- R3: A write anywhere in 0x2000–0x3FFF loads the low bank register from data bits 4:0. If those five bits are zero, the register becomes 1, even when bits 7:5 are set.
- R4: A write anywhere in 0x4000–0x5FFF loads the high bank register from data bits 1:0. Bits 7:2 are ignored.
- R5: A write anywhere in 0x6000–0x7FFF loads the mode bit from data bit 0. Bits 7:1 are ignored.
- R6: A read in 0x4000–0x7FFF drives physical ROM address = bank × 0x4000 + CPU address bits 13:0, where bank = (high << 5) | low.
- R7: A read in 0x0000–0x3FFF uses bank (high << 5) when the mode bit is 1, and bank 0 when it is 0.
- R8: A RAM-window access drives physical RAM address = bank × 0x2000 + CPU address bits 12:0. The bank is the high register when the mode bit is 1, and 0 otherwise.
- R9: A write in 0xA000–0xBFFF asserts the RAM select and RAM write strobe only while RAM is enabled. While RAM is disabled, both stay low.
- R10: A read in 0xA000–0xBFFF while RAM is disabled keeps the RAM select low and raises the fill output, which tells the bus to return 0xFF. The fill output is low in every other case.
- R11: Before forming the physical address, the ROM bank is ANDed with ROM_BANKS−1 and the RAM bank with RAM_BANKS−1. For example, with 16 ROM banks, bank 0x75 maps to bank 5, and with 2 RAM banks, high = 3 maps to RAM bank 1.
- R12: The ROM select is high only for reads of 0x0000–0x7FFF. Writes there, and any access at or above 0x8000, never select ROM. Register writes never select RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe; sampled at the clock edge for register writes |
| rom_addr | output | ROM_AW (21) | Physical ROM byte address |
| rom_cs | output | 1 | ROM chip select |
| ram_addr | output | RAM_AW (15) | Physical RAM byte address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write strobe |
| rd_fill | output | 1 | Bus must return 0xFF (read of disabled RAM) |

## Verification
The hardest cases to reach are the ones that depend on several registers set in the right order. One is the lower ROM window showing a nonzero bank, which needs both a nonzero high register and mode 1 to be in place. Another is masking that actually truncates a bank, which only happens with a configuration smaller than the default. The stimulus sets the registers through ordinary writes into the ROM range, then probes each window. A second, reduced instance shares the same inputs so that the masking is visible at its ports. The zero-to-one promotion is reached through data bytes whose upper bits are set but whose low five bits are zero.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    localparam int ROM_OFS_BITS = 14;
    localparam int RAM_OFS_BITS = 13;

    typedef struct packed {
        logic       ram_en;
        logic [4:0] lo;
        logic [1:0] hi;
        logic       mode;
    } bank_ctl_t;

    localparam bank_ctl_t CTL_RESET = '{ram_en: 1'b0, lo: 5'd1, hi: 2'd0, mode: 1'b0};

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_LOW    = 2'd1,
        REG_HIGH   = 2'd2,
        REG_MODE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        WIN_ROM_LO,
        WIN_ROM_HI,
        WIN_RAM,
        WIN_NONE
    } win_e;

    function automatic win_e decode_win(input logic [15:0] a);
        if (!a[15])                 return a[14] ? WIN_ROM_HI : WIN_ROM_LO;
        else if (a[15:13] == 3'b101) return WIN_RAM;
        else                        return WIN_NONE;
    endfunction

    function automatic logic [4:0] promote_low(input logic [4:0] v);
        return (v == 5'd0) ? 5'd1 : v;
    endfunction

endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
    import cart_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_stb,
    input  reg_sel_e  sel,
    input  logic [7:0] wdata,
    output bank_ctl_t ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CTL_RESET;
        end else if (wr_stb) begin
            unique case (sel)
                REG_ENABLE: ctl.ram_en <= (wdata[3:0] == 4'hA);
                REG_LOW:    ctl.lo     <= promote_low(wdata[4:0]);
                REG_HIGH:   ctl.hi     <= wdata[1:0];
                REG_MODE:   ctl.mode   <= wdata[0];
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/cbc_addr_map.sv
module cbc_addr_map
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 128,
    parameter int RAM_BANKS = 4,
    parameter int ROM_BW    = 7,
    parameter int RAM_BW    = 2
) (
    input  bank_ctl_t                          ctl,
    input  logic [15:0]                        addr,
    output logic [ROM_BW+ROM_OFS_BITS-1:0]     rom_addr,
    output logic [RAM_BW+RAM_OFS_BITS-1:0]     ram_addr
);
    localparam logic [6:0] ROM_MASK = 7'(ROM_BANKS - 1);
    localparam logic [1:0] RAM_MASK = 2'(RAM_BANKS - 1);

    logic [6:0] rom_bank_raw;
    logic [6:0] rom_bank;
    logic [1:0] ram_bank;

    always_comb begin
        if (addr[14])      rom_bank_raw = {ctl.hi, ctl.lo};
        else if (ctl.mode) rom_bank_raw = {ctl.hi, 5'd0};
        else               rom_bank_raw = 7'd0;
        rom_bank = rom_bank_raw & ROM_MASK;
        ram_bank = (ctl.mode ? ctl.hi : 2'd0) & RAM_MASK;
    end

    assign rom_addr = {rom_bank[ROM_BW-1:0], addr[ROM_OFS_BITS-1:0]};

    generate
        if (RAM_BW > 0) begin : g_ram_banked
            assign ram_addr = {ram_bank[RAM_BW-1:0], addr[RAM_OFS_BITS-1:0]};
        end else begin : g_ram_flat
            logic unused_bank;
            assign unused_bank = ^ram_bank;
            assign ram_addr    = addr[RAM_OFS_BITS-1:0];
        end
    endgenerate
endmodule

// File: rtl/cbc_select.sv
module cbc_select
    import cart_bank_pkg::*;
(
    input  win_e win,
    input  logic rd,
    input  logic wr,
    input  logic ram_en,
    output logic rom_cs,
    output logic ram_cs,
    output logic ram_we,
    output logic rd_fill
);
    logic in_rom, in_ram;
    always_comb begin
        in_rom  = (win == WIN_ROM_LO) || (win == WIN_ROM_HI);
        in_ram  = (win == WIN_RAM);
        rom_cs  = rd && in_rom;
        ram_cs  = (rd || wr) && in_ram && ram_en;
        ram_we  = wr && in_ram && ram_en;
        rd_fill = rd && in_ram && !ram_en;
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 128,
    parameter int RAM_BANKS = 4,
    localparam int ROM_BW = $clog2(ROM_BANKS),
    localparam int RAM_BW = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 0,
    localparam int ROM_AW = ROM_BW + ROM_OFS_BITS,
    localparam int RAM_AW = RAM_BW + RAM_OFS_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_cs,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic              rd_fill
);
    bank_ctl_t ctl;
    win_e      win;
    logic      reg_wr;

    assign win    = decode_win(cpu_addr);
    assign reg_wr = cpu_wr && !cpu_addr[15];

    cbc_ctrl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (reg_wr),
        .sel    (reg_sel_e'(cpu_addr[14:13])),
        .wdata  (cpu_wdata),
        .ctl    (ctl)
    );

    cbc_addr_map #(
        .ROM_BANKS (ROM_BANKS),
        .RAM_BANKS (RAM_BANKS),
        .ROM_BW    (ROM_BW),
        .RAM_BW    (RAM_BW)
    ) u_map (
        .ctl      (ctl),
        .addr     (cpu_addr),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr)
    );

    cbc_select u_sel (
        .win     (win),
        .rd      (cpu_rd),
        .wr      (cpu_wr),
        .ram_en  (ctl.ram_en),
        .rom_cs  (rom_cs),
        .ram_cs  (ram_cs),
        .ram_we  (ram_we),
        .rd_fill (rd_fill)
    );
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker
    import cart_bank_pkg::*;
#(
    parameter int ROM_AW = 21,
    parameter int RAM_AW = 15
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              rom_cs,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              ram_cs,
    input logic              ram_we,
    input logic              rd_fill,
    input bank_ctl_t         ctl
);
    AST_EN_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b000) |=> (ctl.ram_en == ($past(cpu_wdata[3:0]) == 4'hA))); // R2
    AST_LOW_NONZERO: assert property (@(posedge clk) disable iff (rst)
        ctl.lo != 5'd0); // R3
    AST_LOWER_MODE0: assert property (@(posedge clk) disable iff (rst)
        (rom_cs && !cpu_addr[14] && !ctl.mode) |-> (rom_addr[ROM_AW-1:ROM_OFS_BITS] == '0)); // R7
    AST_RAM_OFFSET: assert property (@(posedge clk) disable iff (rst)
        ram_cs |-> (ram_addr[RAM_OFS_BITS-1:0] == cpu_addr[RAM_OFS_BITS-1:0])); // R8
    AST_RAM_GATED: assert property (@(posedge clk) disable iff (rst)
        (ram_cs || ram_we) |-> (cpu_addr[15:13] == 3'b101 && ctl.ram_en)); // R9
    AST_FILL_EXCL: assert property (@(posedge clk) disable iff (rst)
        rd_fill |-> (!ram_cs && cpu_rd)); // R10
    AST_ROM_CS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> (cpu_rd && !cpu_addr[15])); // R12
endmodule

bind cart_bank_ctrl cbc_checker #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_chk (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(rom_addr), .rom_cs(rom_cs),
    .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we), .rd_fill(rd_fill),
    .ctl(ctl)
);

// File: tb/cart_bank_ctrl_bench.sv
module cart_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;

    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        rom_cs, ram_cs, ram_we, rd_fill;
    logic [17:0] s_rom_addr;
    logic [13:0] s_ram_addr;
    logic        s_rom_cs, s_ram_cs, s_ram_we, s_rd_fill;

    int checks = 0, fails = 0;
    bit done = 0;

    // model state derived from the requirements
    bit       m_en = 0, m_mode = 0;
    bit [4:0] m_lo = 1;
    bit [1:0] m_hi = 0;

    always #5 clk = ~clk;

    cart_bank_ctrl u_cart_bank_ctrl (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(rom_addr), .rom_cs(rom_cs),
        .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we), .rd_fill(rd_fill)
    );

    cart_bank_ctrl #(.ROM_BANKS(16), .RAM_BANKS(2)) u_small (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(s_rom_addr), .rom_cs(s_rom_cs),
        .ram_addr(s_ram_addr), .ram_cs(s_ram_cs), .ram_we(s_ram_we), .rd_fill(s_rd_fill)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_rom(input logic [15:0] a, input int banks);
        int b;
        if (a[14])       b = {m_hi, m_lo};
        else if (m_mode) b = {m_hi, 5'd0};
        else             b = 0;
        b = b & (banks - 1);
        return (b << 14) | int'(a[13:0]);
    endfunction

    function automatic int exp_ram(input logic [15:0] a, input int banks);
        int b;
        b = m_mode ? int'(m_hi) : 0;
        b = b & (banks - 1);
        return (b << 13) | int'(a[12:0]);
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_rd = 0; cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
        if (!a[15]) begin
            case (a[14:13])
                2'd0: m_en = (d[3:0] == 4'hA);
                2'd1: m_lo = (d[4:0] == 0) ? 5'd1 : d[4:0];
                2'd2: m_hi = d[1:0];
                default: m_mode = d[0];
            endcase
        end
        @(negedge clk);
        cpu_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        cpu_wr = 0; cpu_addr = a; cpu_rd = 1;
        #1;
    endtask

    task automatic rom_probe(input string req, input logic [15:0] a);
        rd(a);
        chk(req, int'(rom_cs), 1);
        chk(req, int'(rom_addr), exp_rom(a, 128));
    endtask

    task automatic t_reset();
        rom_probe("R1", 16'h4000);
        chk("R1", int'(rom_addr), 32'h04000);
        rom_probe("R1", 16'h0123);
        rd(16'hA000);
        chk("R1", int'(ram_cs), 0);
        chk("R10", int'(rd_fill), 1);
    endtask

    task automatic t_enable();
        wr(16'h0000, 8'h3A); rd(16'hA005);
        chk("R2", int'(ram_cs), 1); chk("R10", int'(rd_fill), 0);
        wr(16'h1FFF, 8'h0B); rd(16'hA005);
        chk("R2", int'(ram_cs), 0); chk("R10", int'(rd_fill), 1);
        wr(16'h1000, 8'hFA); rd(16'hBFFF);
        chk("R2", int'(ram_cs), 1);
        chk("R8", int'(ram_addr), exp_ram(16'hBFFF, 4));
    endtask

    task automatic t_low();
        wr(16'h2000, 8'h00); rom_probe("R3", 16'h4000);
        chk("R3", int'(rom_addr), 32'h04000);
        wr(16'h3FFF, 8'hE5); rom_probe("R6", 16'h7ABC);
        chk("R3", int'(rom_addr), (5 << 14) | 32'h3ABC);
        wr(16'h2100, 8'h20); rom_probe("R3", 16'h5000);
        chk("R3", int'(rom_addr), (1 << 14) | 32'h1000);
        wr(16'h2000, 8'h05);
    endtask

    task automatic t_high();
        wr(16'h4000, 8'hFE); rom_probe("R4", 16'h7ABC);
        chk("R6", int'(rom_addr), (32'h45 << 14) | 32'h3ABC);
        rom_probe("R7", 16'h1234);
        chk("R7", int'(rom_addr), 32'h1234);
        rd(16'hB456);
        chk("R8", int'(ram_addr), 32'h1456);
    endtask

    task automatic t_mode();
        wr(16'h6000, 8'hFF); rom_probe("R5", 16'h1234);
        chk("R7", int'(rom_addr), (32'h40 << 14) | 32'h1234);
        rd(16'hB456);
        chk("R8", int'(ram_addr), (2 << 13) | 32'h1456);
        wr(16'h7000, 8'h02); rom_probe("R5", 16'h1234);
        chk("R5", int'(rom_addr), 32'h1234);
    endtask

    task automatic t_ram_write();
        @(negedge clk); cpu_rd = 0; cpu_addr = 16'hA010; cpu_wdata = 8'h55; cpu_wr = 1; #1;
        chk("R9", int'(ram_we), 1); chk("R9", int'(ram_cs), 1);
        chk("R8", int'(ram_addr), exp_ram(16'hA010, 4));
        @(negedge clk); cpu_wr = 0;
        wr(16'h0000, 8'h00);
        @(negedge clk); cpu_addr = 16'hA010; cpu_wr = 1; #1;
        chk("R9", int'(ram_we), 0); chk("R9", int'(ram_cs), 0);
        @(negedge clk); cpu_wr = 0;
        @(negedge clk); cpu_addr = 16'h6000; cpu_wdata = 8'h00; cpu_wr = 1; #1;
        chk("R12", int'(rom_cs), 0); chk("R12", int'(ram_cs), 0);
        @(negedge clk); cpu_wr = 0;
        rd(16'hC000);
        chk("R12", int'(rom_cs), 0); chk("R12", int'(ram_cs), 0);
        chk("R10", int'(rd_fill), 0);
    endtask

    task automatic t_mask();
        wr(16'h2000, 8'h15); wr(16'h4000, 8'h03); wr(16'h6000, 8'h01); wr(16'h0000, 8'h0A);
        rd(16'h6ABC);
        chk("R11", int'(s_rom_addr), exp_rom(16'h6ABC, 16));
        chk("R11", int'(s_rom_addr), (5 << 14) | 32'h2ABC);
        chk("R11", int'(rom_addr), (32'h75 << 14) | 32'h2ABC);
        rd(16'h0100);
        chk("R11", int'(s_rom_addr), 32'h0100);
        rd(16'hA777);
        chk("R11", int'(s_ram_addr), 32'h2777);
        chk("R11", int'(ram_addr), (3 << 13) | 32'h0777);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_enable();
        t_low();
        t_high();
        t_mode();
        t_ram_write();
        t_mask();
        @(negedge clk); cpu_rd = 0;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule